// File: doc/BRIEF.md
# Serial Audio Direction Control and Status Register

This block is the control and status word for one direction (transmit or receive) of a serial audio port. Software reaches it through a single-cycle read/write port. It holds the run enable for the serializer, a DMA request enable, five interrupt enables and five event flags. It also has a write-only FIFO reset trigger and a software reset that holds the datapath in reset while it is set. A second address holds the FIFO watermark.

The datapath and the FIFO feed it one-cycle event strobes, the FIFO fill level and an end-of-frame strobe. The block drives the interrupt line, the DMA request, a one-cycle FIFO pointer reset and the datapath reset. It also drives the run enable seen by the serializer. When software clears the run enable, that enable stays on until the current frame has been shifted out.

The parameter `IS_RX` picks the direction:

- **Receive:** the warning flag means the FIFO is full, and the watermark flag means the fill level is above the watermark.
- **Transmit:** the warning flag means the FIFO is empty, and the watermark flag means the fill level is at or below the watermark.

Top module: `aud_csr`

## Requirements
- R1: After reset, both registers read as zero, and `irq`, `dmaReq`, `fifoRstPulse`, `dpRst` and `xferEn` are all low. This holds for the receive variant with `fifoLevel` at 0.
- R2: Three control-word bits are sticky flags that latch their one-cycle event input on the next clock edge and then stay set: bit 16 (word start), bit 17 (frame-sync error) and bit 18 (FIFO error).
- R3: Writing 1 to bit 16, 17 or 18 of the control word clears that flag. Writing 0 to it leaves the flag unchanged.
- R4: If an event and a write-one-to-clear reach the same flag in the same cycle, the flag stays set.
- R5: Two flags follow the FIFO live and ignore writes. In the receive variant, bit 19 is set when `fifoLevel` equals DEPTH, and bit 20 is set when `fifoLevel` is greater than the watermark.
- R6: `irq` is high exactly when some flag at bit 16+k is set and its enable at bit 8+k is also set.
- R7: `dmaReq` is the bit-20 watermark flag ANDed with the DMA enable at bit 0.
- R8: Writing 1 to bit 24 of the control word raises `fifoRstPulse` for exactly one cycle, in the cycle after the write. Bit 24 always reads 0.
- R9: Bit 25 is the software reset, and `dpRst` follows it. While bit 25 is set:
  - the run enable, DMA enable, interrupt enables and all flags read 0;
  - events and writes to the other control bits have no effect;
  - the watermark register keeps its value.
  Writing 0 to bit 25 releases the reset.
- R10: Bit 31 is the run enable, and it drives `xferEn`. After software writes it to 0, both the readback and `xferEn` stay 1 until a `frameEnd` pulse. They go low in the cycle after that pulse.
- R11: Address 1 holds the watermark in its low LVL_W bits. Writes to address 1 are read back there, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address (0 control word, 1 watermark) |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for `regAddr`, combinational |
| wordStartEvt | input | 1 | Word start event strobe |
| syncErrEvt | input | 1 | Frame-sync error strobe |
| fifoErrEvt | input | 1 | FIFO underrun/overflow strobe |
| fifoLevel | input | LVL_W | Current FIFO fill level |
| frameEnd | input | 1 | End-of-frame strobe from the serializer |
| irq | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |
| fifoRstPulse | output | 1 | One-cycle FIFO pointer reset |
| dpRst | output | 1 | Datapath reset level |
| xferEn | output | 1 | Run enable seen by the serializer |

## Verification
The assertions assume the following about the inputs:

- The event strobes, `frameEnd` and the write port hold steady around each clock edge and are quiet while `rstN` is low.
- `fifoLevel` never exceeds DEPTH.

The stimulus meets these conditions by driving every input on the falling edge and keeping the event strobes and writes at zero through reset. It moves `fifoLevel` only between 0 and DEPTH. The collision case of R4 is the one place where an event strobe and a register write share a cycle on purpose.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
  localparam int NUM_EVT    = 5;
  localparam int NUM_STICKY = 3;
  // flag order inside the flag and enable fields
  localparam int EVT_WSTART  = 0;
  localparam int EVT_SYNCERR = 1;
  localparam int EVT_FIFOERR = 2;
  localparam int EVT_WARN    = 3;
  localparam int EVT_WMARK   = 4;
  // control word layout
  localparam int BIT_DMAEN = 0;
  localparam int IE_LSB    = 8;
  localparam int FLAG_LSB  = 16;
  localparam int BIT_FRST  = 24;
  localparam int BIT_SRST  = 25;
  localparam int BIT_XEN   = 31;
  // addresses
  localparam int ADDR_CTL = 0;
  localparam int ADDR_WM  = 1;

  typedef struct packed {
    logic [NUM_STICKY-1:0] clrMask;
    logic                  srstNext;
    logic                  drainStart;
    logic                  drainCancel;
  } csrStrobe_t;
endpackage

// File: rtl/aud_csr_ctrl.sv
module aud_csr_ctrl
  import aud_csr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic               xferEnReg,
  output logic               dmaEn,
  output logic [NUM_EVT-1:0] intEn,
  output logic               srst,
  output logic [LVL_W-1:0]   watermark,
  output logic               fifoRstPulse,
  output csrStrobe_t         strobe
);
  logic wrCtl;
  logic wrWm;
  logic srstNext;

  assign wrCtl    = regWrEn && (regAddr == ADDR_W'(ADDR_CTL));
  assign wrWm     = regWrEn && (regAddr == ADDR_W'(ADDR_WM));
  assign srstNext = wrCtl ? regWrData[BIT_SRST] : srst;

  always_comb begin
    strobe             = '0;
    strobe.srstNext    = srstNext;
    strobe.clrMask     = wrCtl ? regWrData[FLAG_LSB +: NUM_STICKY] : '0;
    strobe.drainStart  = wrCtl && !regWrData[BIT_XEN] && xferEnReg && !srstNext;
    strobe.drainCancel = wrCtl && regWrData[BIT_XEN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srst         <= 1'b0;
      fifoRstPulse <= 1'b0;
      xferEnReg    <= 1'b0;
      dmaEn        <= 1'b0;
      intEn        <= '0;
      watermark    <= '0;
    end else begin
      srst         <= srstNext;
      fifoRstPulse <= wrCtl && regWrData[BIT_FRST];
      if (srstNext) begin
        xferEnReg <= 1'b0;
        dmaEn     <= 1'b0;
        intEn     <= '0;
      end else if (wrCtl) begin
        xferEnReg <= regWrData[BIT_XEN];
        dmaEn     <= regWrData[BIT_DMAEN];
        intEn     <= regWrData[IE_LSB +: NUM_EVT];
      end
      if (wrWm) watermark <= regWrData[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/aud_csr_stat.sv
module aud_csr_stat
  import aud_csr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_RX = 1'b1,
  parameter int LVL_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  csrStrobe_t         strobe,
  input  logic               srst,
  input  logic               xferEnReg,
  input  logic               dmaEn,
  input  logic [NUM_EVT-1:0] intEn,
  input  logic [LVL_W-1:0]   watermark,
  input  logic               wordStartEvt,
  input  logic               syncErrEvt,
  input  logic               fifoErrEvt,
  input  logic [LVL_W-1:0]   fifoLevel,
  input  logic               frameEnd,
  output logic [NUM_EVT-1:0] flags,
  output logic               xferActive,
  output logic               irq,
  output logic               dmaReq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [NUM_STICKY-1:0] stickyQ;
  logic [NUM_STICKY-1:0] evtVec;
  logic                  warnRaw;
  logic                  wmRaw;
  logic                  draining;

  assign evtVec = {fifoErrEvt, syncErrEvt, wordStartEvt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stickyQ <= '0;
    else if (strobe.srstNext) stickyQ <= '0;
    else                      stickyQ <= (stickyQ & ~strobe.clrMask) | evtVec;
  end

  generate
    if (IS_RX) begin : g_rx
      assign warnRaw = (fifoLevel >= FULL_LVL);
      assign wmRaw   = (fifoLevel > watermark);
    end else begin : g_tx
      assign warnRaw = (fifoLevel == '0);
      assign wmRaw   = (fifoLevel <= watermark);
    end
  endgenerate

  always_comb begin
    flags                       = '0;
    flags[NUM_STICKY-1:0]       = stickyQ;
    flags[EVT_WARN]             = warnRaw && !srst;
    flags[EVT_WMARK]            = wmRaw && !srst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   draining <= 1'b0;
    else if (strobe.srstNext)                    draining <= 1'b0;
    else if (strobe.drainStart && !frameEnd)     draining <= 1'b1;
    else if (strobe.drainCancel || frameEnd)     draining <= 1'b0;
  end

  assign xferActive = xferEnReg || draining;
  assign irq        = |(flags & intEn);
  assign dmaReq     = flags[EVT_WMARK] && dmaEn;
endmodule

// File: rtl/aud_csr.sv
module aud_csr
  import aud_csr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter bit IS_RX  = 1'b1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              wordStartEvt,
  input  logic              syncErrEvt,
  input  logic              fifoErrEvt,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              frameEnd,
  output logic              irq,
  output logic              dmaReq,
  output logic              fifoRstPulse,
  output logic              dpRst,
  output logic              xferEn
);
  csrStrobe_t         strobe;
  logic               xferEnReg;
  logic               dmaEn;
  logic [NUM_EVT-1:0] intEn;
  logic               srst;
  logic [LVL_W-1:0]   watermark;
  logic [NUM_EVT-1:0] flagView;
  logic               xferActive;

  aud_csr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .xferEnReg(xferEnReg), .dmaEn(dmaEn),
    .intEn(intEn), .srst(srst), .watermark(watermark),
    .fifoRstPulse(fifoRstPulse), .strobe(strobe)
  );

  aud_csr_stat #(.DEPTH(DEPTH), .IS_RX(IS_RX), .LVL_W(LVL_W)) u_stat (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srst(srst),
    .xferEnReg(xferEnReg), .dmaEn(dmaEn), .intEn(intEn),
    .watermark(watermark), .wordStartEvt(wordStartEvt),
    .syncErrEvt(syncErrEvt), .fifoErrEvt(fifoErrEvt),
    .fifoLevel(fifoLevel), .frameEnd(frameEnd), .flags(flagView),
    .xferActive(xferActive), .irq(irq), .dmaReq(dmaReq)
  );

  assign dpRst  = srst;
  assign xferEn = xferActive;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTL)) begin
      regRdData[BIT_XEN]                 = xferActive;
      regRdData[BIT_SRST]                = srst;
      regRdData[FLAG_LSB +: NUM_EVT]     = flagView;
      regRdData[IE_LSB +: NUM_EVT]       = intEn;
      regRdData[BIT_DMAEN]               = dmaEn;
    end else if (regAddr == ADDR_W'(ADDR_WM)) begin
      regRdData[LVL_W-1:0] = watermark;
    end
  end
endmodule

// File: rtl/aud_csr_chk.sv
module aud_csr_chk
  import aud_csr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              wordStartEvt,
  input logic              syncErrEvt,
  input logic              fifoErrEvt,
  input logic              frameEnd,
  input logic              irq,
  input logic              dmaReq,
  input logic              fifoRstPulse,
  input logic              dpRst,
  input logic              xferEn,
  input logic [NUM_EVT-1:0] flagView
);
  logic ctlWr;
  assign ctlWr = regWrEn && (regAddr == ADDR_W'(ADDR_CTL));

  // R8
  frst_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && regWrData[BIT_FRST]) |=> fifoRstPulse);

  // R8
  frst_oneshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctlWr && regWrData[BIT_FRST]) |=> !fifoRstPulse);

  // R9
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpRst |-> (!irq && !dmaReq && !xferEn && (flagView == '0)));

  // R10
  xen_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xferEn) |-> ($past(frameEnd) || $past(ctlWr && regWrData[BIT_SRST])));

  // R2 R4
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordStartEvt || syncErrEvt || fifoErrEvt) |=>
      (dpRst || ((($past({fifoErrEvt, syncErrEvt, wordStartEvt})) & ~flagView[NUM_STICKY-1:0]) == '0)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagView == '0) |-> !irq);

  // R7
  dma_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> flagView[EVT_WMARK]);
endmodule

bind aud_csr aud_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/aud_csr_tb.sv
module aud_csr_tb;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  localparam logic [31:0] F_WS   = 32'h0001_0000;
  localparam logic [31:0] F_SE   = 32'h0002_0000;
  localparam logic [31:0] F_FE   = 32'h0004_0000;
  localparam logic [31:0] F_WARN = 32'h0008_0000;
  localparam logic [31:0] F_WM   = 32'h0010_0000;
  localparam logic [31:0] IE_WS  = 32'h0000_0100;
  localparam logic [31:0] IE_WM  = 32'h0000_1000;
  localparam logic [31:0] DMAE   = 32'h0000_0001;
  localparam logic [31:0] FRST   = 32'h0100_0000;
  localparam logic [31:0] SRST   = 32'h0200_0000;
  localparam logic [31:0] XEN    = 32'h8000_0000;

  logic              clk = 1'b0;
  logic              rstN;
  logic              regWrEn;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] regWrData;
  logic [DATA_W-1:0] regRdData;
  logic              wordStartEvt, syncErrEvt, fifoErrEvt, frameEnd;
  logic [LVL_W-1:0]  fifoLevel;
  logic              irq, dmaReq, fifoRstPulse, dpRst, xferEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  aud_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IS_RX(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .wordStartEvt(wordStartEvt), .syncErrEvt(syncErrEvt),
    .fifoErrEvt(fifoErrEvt), .fifoLevel(fifoLevel), .frameEnd(frameEnd),
    .irq(irq), .dmaReq(dmaReq), .fifoRstPulse(fifoRstPulse),
    .dpRst(dpRst), .xferEn(xferEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rdReg(0, v); chk("R1 control word", v, 32'h0);
    rdReg(1, v); chk("R1 watermark", v, 32'h0);
    chk("R1 outputs", {27'h0, irq, dmaReq, fifoRstPulse, dpRst, xferEn}, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    @(negedge clk); wordStartEvt = 1'b1;
    @(negedge clk); wordStartEvt = 1'b0;
    idle(2);
    rdReg(0, v); chk("R2 word start latched", v, F_WS);
    @(negedge clk); syncErrEvt = 1'b1; fifoErrEvt = 1'b1;
    @(negedge clk); syncErrEvt = 1'b0; fifoErrEvt = 1'b0;
    rdReg(0, v); chk("R2 three flags", v, F_WS | F_SE | F_FE);
    wrReg(0, F_SE);
    rdReg(0, v); chk("R3 clear one flag", v, F_WS | F_FE);
    wrReg(0, 32'h0);
    rdReg(0, v); chk("R3 write zero keeps", v, F_WS | F_FE);
    wrReg(0, F_WS | F_SE | F_FE);
    rdReg(0, v); chk("R3 clear all", v, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk); fifoErrEvt = 1'b1;
    @(negedge clk); fifoErrEvt = 1'b0;
    @(negedge clk);
    fifoErrEvt = 1'b1; regWrEn = 1'b1; regAddr = 0; regWrData = F_FE;
    @(negedge clk);
    fifoErrEvt = 1'b0; regWrEn = 1'b0; regWrData = '0;
    rdReg(0, v); chk("R4 event beats clear", v, F_FE);
    wrReg(0, F_FE);
    rdReg(0, v); chk("R4 later clear", v, 32'h0);
  endtask

  task automatic t_live();
    logic [31:0] v;
    wrReg(1, 32'd4);
    rdReg(1, v); chk("R11 watermark readback", v, 32'd4);
    rdReg(2, v); chk("R11 unused address", v, 32'h0);
    @(negedge clk); fifoLevel = 4;
    rdReg(0, v); chk("R5 level equal watermark", v, 32'h0);
    @(negedge clk); fifoLevel = 5;
    rdReg(0, v); chk("R5 level above watermark", v, F_WM);
    @(negedge clk); fifoLevel = LVL_W'(DEPTH);
    rdReg(0, v); chk("R5 full", v, F_WM | F_WARN);
    wrReg(0, F_WM | F_WARN);
    rdReg(0, v); chk("R5 writes ignored", v, F_WM | F_WARN);
    @(negedge clk); fifoLevel = 0;
    rdReg(0, v); chk("R5 empty clears", v, 32'h0);
  endtask

  task automatic t_irq();
    wrReg(0, IE_WS);
    chk("R6 enabled but no flag", {31'h0, irq}, 32'h0);
    @(negedge clk); syncErrEvt = 1'b1;
    @(negedge clk); syncErrEvt = 1'b0;
    chk("R6 unmasked flag only", {31'h0, irq}, 32'h0);
    @(negedge clk); wordStartEvt = 1'b1;
    @(negedge clk); wordStartEvt = 1'b0;
    chk("R6 enabled flag", {31'h0, irq}, 32'h1);
    wrReg(0, IE_WS | F_WS | F_SE);
    chk("R6 after clear", {31'h0, irq}, 32'h0);
    wrReg(0, IE_WM);
    @(negedge clk); fifoLevel = 5;
    #1 chk("R6 live watermark", {31'h0, irq}, 32'h1);
    @(negedge clk); fifoLevel = 0;
    #1 chk("R6 live drop", {31'h0, irq}, 32'h0);
    wrReg(0, 32'h0);
  endtask

  task automatic t_dma();
    @(negedge clk); fifoLevel = 5;
    #1 chk("R7 dma disabled", {31'h0, dmaReq}, 32'h0);
    wrReg(0, DMAE);
    chk("R7 dma enabled", {31'h0, dmaReq}, 32'h1);
    @(negedge clk); fifoLevel = 3;
    #1 chk("R7 below watermark", {31'h0, dmaReq}, 32'h0);
    wrReg(0, 32'h0);
    @(negedge clk); fifoLevel = 0;
  endtask

  task automatic t_fifo_rst();
    logic [31:0] v;
    chk("R8 idle", {31'h0, fifoRstPulse}, 32'h0);
    wrReg(0, FRST);
    chk("R8 pulse", {31'h0, fifoRstPulse}, 32'h1);
    rdReg(0, v); chk("R8 reads zero", v, 32'h0);
    @(negedge clk);
    chk("R8 single cycle", {31'h0, fifoRstPulse}, 32'h0);
  endtask

  task automatic t_xfer();
    logic [31:0] v;
    wrReg(0, XEN);
    rdReg(0, v); chk("R10 enable set", v, XEN);
    chk("R10 xferEn on", {31'h0, xferEn}, 32'h1);
    @(negedge clk); frameEnd = 1'b1;
    @(negedge clk); frameEnd = 1'b0;
    chk("R10 frameEnd while enabled", {31'h0, xferEn}, 32'h1);
    wrReg(0, 32'h0);
    idle(3);
    rdReg(0, v); chk("R10 draining readback", v, XEN);
    chk("R10 draining xferEn", {31'h0, xferEn}, 32'h1);
    @(negedge clk); frameEnd = 1'b1;
    @(negedge clk); frameEnd = 1'b0;
    rdReg(0, v); chk("R10 stopped after frame", v, 32'h0);
    chk("R10 xferEn off", {31'h0, xferEn}, 32'h0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wrReg(1, 32'd7);
    wrReg(0, XEN | IE_WS | DMAE);
    @(negedge clk); wordStartEvt = 1'b1;
    @(negedge clk); wordStartEvt = 1'b0;
    wrReg(0, SRST);
    chk("R9 dpRst high", {31'h0, dpRst}, 32'h1);
    rdReg(0, v); chk("R9 fields cleared", v, SRST);
    chk("R9 xferEn off at once", {31'h0, xferEn}, 32'h0);
    @(negedge clk); wordStartEvt = 1'b1; fifoLevel = LVL_W'(DEPTH);
    @(negedge clk); wordStartEvt = 1'b0;
    rdReg(0, v); chk("R9 events ignored", v, SRST);
    wrReg(0, SRST | XEN | IE_WS | DMAE);
    rdReg(0, v); chk("R9 writes ignored", v, SRST);
    rdReg(1, v); chk("R9 watermark kept", v, 32'd7);
    @(negedge clk); fifoLevel = 0;
    wrReg(0, 32'h0);
    chk("R9 released", {31'h0, dpRst}, 32'h0);
    rdReg(0, v); chk("R9 clean after release", v, 32'h0);
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    wordStartEvt = 1'b0; syncErrEvt = 1'b0; fifoErrEvt = 1'b0;
    frameEnd = 1'b0; fifoLevel = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_sticky();
    t_collision();
    t_live();
    t_irq();
    t_dma();
    t_fifo_rst();
    t_xfer();
    t_srst();
    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule